// File: doc/BRIEF.md
# Nested Priority Interrupt and Trap Controller

This controller sits between the interrupt sources of a processor and its core. It accepts four classes of external request: program errors such as overflow, divide by zero or an illegal memory reference; the timer; I/O; and hardware failure such as power loss or a memory parity error. It also accepts a trap input. The trap reports an internal event that is already aligned with the current instruction. The controller picks one waiting request and presents it to the core as a 3-bit level code. It holds that code until the core takes it.

External requests arrive at any time relative to the processor clock. Each one passes through a synchronizer. The rising edge of the synchronized request is then held as a pending flag. The trap is sampled directly and outranks every external class.

A stack of in-service flags, one per level, records which handlers are running. An end-of-service strobe retires the most recently nested handler. The service discipline can be changed at run time with a single input:
- Sequential mode shuts out new external requests while any handler runs.
- Nested mode lets a higher-priority request cut into a lower one.

A global enable gates the external classes. It never gates the trap.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no requests, irq_valid is 0 and in_service is all zero.
- R2: Level codes are 0 for program, 1 for I/O, 2 for timer, 3 for hardware failure and 4 for trap. External request bit k carries level k. A rising edge on an external request line becomes pending after a two-flop synchronizer plus an edge detector. irq_valid therefore rises on the fourth clock edge after the line is first sampled high, and not before.
- R3: When several eligible requests are pending, the one with the highest level code is presented.
- R4: Once irq_valid is high, it and irq_vec stay unchanged until a cycle with irq_ack high.
- R5: A cycle with irq_valid and irq_ack both high does three things. It clears that level's pending flag, sets bit irq_vec of in_service, and drives irq_valid low on the next cycle. An irq_ack seen without irq_valid has no effect.
- R6: When nest_mode is 1, an external level is presented only if its code is above the highest level set in in_service.
- R7: When nest_mode is 0, no external level is presented while any in_service bit is set. Pending requests are presented once in_service empties.
- R8: A one-cycle eos pulse clears only the highest set bit of in_service. This resumes the level it preempted.
- R9: While glb_en is 0, no external level is presented, but external pending flags are kept. They are presented after glb_en returns to 1.
- R10: A trap_req pulse becomes pending on the next edge. If no trap is in service, it is presented on the edge after that, regardless of glb_en, nest_mode or external levels in service. While in_service bit 4 is set, a new trap waits until that bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 4 | External requests: bit0 program, bit1 I/O, bit2 timer, bit3 hardware failure |
| trap_req | input | 1 | Synchronous trap request pulse |
| irq_ack | input | 1 | Core takes the presented request |
| eos | input | 1 | End of service of the innermost running handler |
| nest_mode | input | 1 | 1 selects nested service, 0 selects sequential service |
| glb_en | input | 1 | Enables the external request classes |
| irq_valid | output | 1 | A request is being presented |
| irq_vec | output | 3 | Level code of the presented request |
| in_service | output | 5 | One bit per level whose handler is running |

## Verification
A corrupted in-service stack shows up in two ways. A lower level can appear while a higher handler should still block it. Or a pending request can stay hidden after eos should have released it. Either shows at irq_valid within two cycles of the eos or ack that exposes it. A lost or doubled pending flag changes how many presentations follow a burst of requests. For that reason the bench drains every random burst and checks both the exact order of level codes and that irq_valid falls silent afterward. Synchronizer depth errors move the first irq_valid by a cycle, so the bench samples at the exact edge count where irq_valid must rise and one edge before it.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC = 4,
  localparam int VW = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic            trap_req,
  input  logic            irq_ack,
  input  logic            eos,
  input  logic            nest_mode,
  input  logic            glb_en,
  output logic            irq_valid,
  output logic [VW-1:0]   irq_vec,
  output logic [NSRC:0]   in_service
);

  logic [NSRC-1:0] sy1, sy2, sy3, pend;
  logic            pend_trap;
  logic [NSRC:0]   req, elig, top_oh, grant_oh;
  logic [VW:0]     top_p1;
  logic [VW-1:0]   pick;
  logic            found;

  wire take    = irq_valid & irq_ack;
  wire any_svc = |in_service;

  assign req      = {pend_trap, pend & {NSRC{glb_en}}};
  assign grant_oh = take ? ((NSRC+1)'(1) << irq_vec) : '0;

  always_comb begin
    top_p1 = '0;
    top_oh = '0;
    for (int i = 0; i <= NSRC; i++)
      if (in_service[i]) begin
        top_p1 = (VW+1)'(i + 1);
        top_oh = '0;
        top_oh[i] = 1'b1;
      end
  end

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      elig[i] = req[i] & (nest_mode ? ((VW+1)'(i + 1) > top_p1) : !any_svc);
    elig[NSRC] = req[NSRC] & !in_service[NSRC];
  end

  always_comb begin
    found = |elig;
    pick  = '0;
    for (int i = 0; i <= NSRC; i++)
      if (elig[i]) pick = VW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1        <= '0;
      sy2        <= '0;
      sy3        <= '0;
      pend       <= '0;
      pend_trap  <= 1'b0;
      in_service <= '0;
      irq_valid  <= 1'b0;
      irq_vec    <= '0;
    end else begin
      sy1        <= src_req;
      sy2        <= sy1;
      sy3        <= sy2;
      pend       <= (pend & ~grant_oh[NSRC-1:0]) | (sy2 & ~sy3);
      pend_trap  <= (pend_trap & ~grant_oh[NSRC]) | trap_req;
      in_service <= (in_service & ~(eos ? top_oh : '0)) | grant_oh;
      if (irq_valid) begin
        if (irq_ack) irq_valid <= 1'b0;
      end else if (found) begin
        irq_valid <= 1'b1;
        irq_vec   <= pick;
      end
    end
  end

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NSRC = 4,
  localparam int VW = $clog2(NSRC + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_ack,
  input logic          eos,
  input logic          nest_mode,
  input logic          glb_en,
  input logic          irq_valid,
  input logic [VW-1:0] irq_vec,
  input logic [NSRC:0] in_service
);

  logic [VW:0] hi_p1;
  always_comb begin
    hi_p1 = '0;
    for (int i = 0; i <= NSRC; i++)
      if (in_service[i]) hi_p1 = (VW+1)'(i + 1);
  end

  // R2
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> int'(irq_vec) <= NSRC);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ack |=> irq_valid && $stable(irq_vec));

  // R5
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ack |=> !irq_valid);

  // R5
  ack_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ack && !eos |=> in_service[$past(irq_vec)]);

  // R6
  nest_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) && $past(nest_mode) && int'(irq_vec) != NSRC
    |-> int'(irq_vec) + 1 > int'($past(hi_p1)));

  // R7
  seq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) && !$past(nest_mode) && int'(irq_vec) != NSRC
    |-> $past(in_service) == '0);

  // R9
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) && !$past(glb_en) |-> int'(irq_vec) == NSRC);

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .eos(eos),
  .nest_mode(nest_mode), .glb_en(glb_en), .irq_valid(irq_valid),
  .irq_vec(irq_vec), .in_service(in_service)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_req = '0;
  logic       trap_req = 1'b0, irq_ack = 1'b0, eos = 1'b0;
  logic       nest_mode = 1'b1, glb_en = 1'b1;
  logic       irq_valid;
  logic [2:0] irq_vec;
  logic [4:0] in_service;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .trap_req(trap_req),
    .irq_ack(irq_ack), .eos(eos), .nest_mode(nest_mode), .glb_en(glb_en),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .in_service(in_service)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog (all): cycles %0d expected < 100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_pres(input string req, input int v);
    chk(irq_valid === 1'b1 && int'(irq_vec) == v, req,
        irq_valid ? int'(irq_vec) : -1, v);
  endtask

  task automatic chk_idle(input string req);
    chk(irq_valid === 1'b0, req, int'(irq_valid), 0);
  endtask

  task automatic chk_svc(input string req, input int v);
    chk(int'(in_service) == v, req, int'(in_service), v);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_src(input logic [3:0] m);
    src_req = m; tick(3); src_req = '0;
  endtask

  task automatic do_ack();
    irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
  endtask

  task automatic do_eos();
    eos = 1'b1; tick(1); eos = 1'b0;
  endtask

  function automatic int hi_bit(input logic [3:0] m);
    int h = -1;
    for (int i = 0; i < 4; i++) if (m[i]) h = i;
    return h;
  endfunction

  initial begin
    process::self().srandom(32'd1357);
    tick(3);
    chk_idle("R1 reset valid");
    chk_svc("R1 reset stack", 0);
    rst_n = 1'b1;
    tick(2);
    chk_idle("R1 idle after reset");

    // latency and hold
    src_req = 4'b0010; tick(3);
    chk_idle("R2 not before fourth edge");
    tick(1);
    chk_pres("R2 I/O presented", 1);
    src_req = '0; tick(5);
    chk_pres("R4 held without ack", 1);
    do_ack();
    chk_idle("R5 valid drops after ack");
    chk_svc("R5 stack marks I/O", 5'b00010);
    do_ack();
    chk_svc("R5 stray ack ignored", 5'b00010);

    // nested preemption
    pulse_src(4'b0100); tick(6);
    chk_pres("R6 timer preempts I/O", 2);
    do_ack();
    chk_svc("R6 nested stack", 5'b00110);
    do_eos();
    chk_svc("R8 eos clears top only", 5'b00010);
    pulse_src(4'b0001); tick(6);
    chk_idle("R6 lower level held");
    do_eos();
    chk_svc("R8 eos empties stack", 0);
    tick(2);
    chk_pres("R6 program after eos", 0);
    do_ack(); do_eos();

    // sequential
    nest_mode = 1'b0;
    pulse_src(4'b0001); tick(6);
    chk_pres("R7 program idle seq", 0);
    do_ack();
    pulse_src(4'b1000); tick(6);
    chk_idle("R7 hw fail held in sequential");
    do_eos(); tick(2);
    chk_pres("R7 hw fail after eos", 3);
    do_ack(); do_eos();

    // global enable
    glb_en = 1'b0;
    pulse_src(4'b0100); tick(6);
    chk_idle("R9 masked while disabled");
    glb_en = 1'b1; tick(2);
    chk_pres("R9 pending kept", 2);
    do_ack(); do_eos();

    // trap in sequential with external in service and mask off
    pulse_src(4'b0010); tick(6); do_ack();
    glb_en = 1'b0;
    trap_req = 1'b1; tick(1); trap_req = 1'b0; tick(1);
    chk_pres("R10 trap two edges", 4);
    do_ack();
    chk_svc("R10 trap in stack", 5'b10010);
    trap_req = 1'b1; tick(1); trap_req = 1'b0; tick(2);
    chk_idle("R10 trap blocked by trap");
    do_eos();
    chk_svc("R8 trap retired", 5'b00010);
    tick(2);
    chk_pres("R10 second trap", 4);
    do_ack(); do_eos(); do_eos();
    chk_svc("R8 all retired", 0);

    // trap outranks pending external
    nest_mode = 1'b1;
    pulse_src(4'b1000); tick(6);
    trap_req = 1'b1; tick(1); trap_req = 1'b0; glb_en = 1'b1; tick(1);
    chk_pres("R10 trap beats hw fail", 4);
    do_ack(); do_eos(); tick(2);
    chk_pres("R3 hw fail follows trap", 3);
    do_ack(); do_eos(); tick(2);

    // random bursts drained in priority order
    for (int it = 0; it < 40; it++) begin
      logic [3:0] m;
      m = 4'($urandom_range(1, 15));
      nest_mode = 1'($urandom_range(0, 1));
      pulse_src(m); tick(6);
      while (m != 0) begin
        int h;
        h = hi_bit(m);
        chk_pres("R3 random order", h);
        do_ack();
        chk_svc("R5 random stack", 1 << h);
        do_eos(); tick(2);
        m[h] = 1'b0;
      end
      chk_idle("R3 burst drained");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule